// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block sends stereo audio samples out over a three-wire serial audio bus: a bit clock, a frame clock that marks which channel is on the wire, and one data line. It is the clock master. Each system-clock cycle in which the bit-tick enable is high toggles the bit clock. The frame clock and the data line are produced in step with the bit clock. A frame is 64 bit periods long and holds a left slot followed by a right slot. Each slot is 32 periods long.

Two framings are supported. In the I²S framing the MSB follows the frame-clock edge by one bit period. In the left-justified framing the MSB starts together with that edge. The sample width can be set from 16 to 24 bits. The framing select and the width are sampled only when a frame starts, so a frame never mixes two settings.

Samples come in as left/right pairs over a valid/ready interface. They go into a one-entry holding register, which is emptied at each frame start. If the register is empty when a frame starts, the previous pair is sent again and an underrun pulse is raised. A tristate input drops the pad output enable so that another transmitter can drive the shared bus. While the pads are released, the counters keep running, so frame alignment is preserved.

Top module: `pcm_serial_tx`

## Requirements
- R1: `fmt_sel` low selects left-justified framing and high selects I²S framing. The value is taken at the frame start.
- R2: The effective width is `width_sel` clamped into 16..24. A request below 16 gives 16 and a request above 24 gives 24. Samples are right-aligned, so bits [w-1:0] carry the value with bit w-1 as MSB, and the bits above are ignored.
- R3: `bclk_o` toggles on every clock edge where `bit_tick` is high and holds its value otherwise.
- R4: `lrck_o` and `sdata_o` change only on the clock edge where `bclk_o` rises.
- R5: A frame is 64 bit periods: left slot in periods 0..31, right slot in 32..63. In left-justified framing `lrck_o` is 1 in the left slot and 0 in the right slot. In I²S framing the levels are reversed.
- R6: In left-justified framing, slot period p carries sample bit w-1-p for p < w and 0 for every later period of the slot.
- R7: In I²S framing, slot period 0 carries 0, period p carries bit w-p for 1 <= p <= w, and the rest of the slot carries 0.
- R8: Changes to `fmt_sel` or `width_sel` during a frame do not affect that frame.
- R9: `smp_ready` is high exactly when the holding register is empty. A pair is accepted when `smp_valid` and `smp_ready` are both high, and the register is emptied at each frame start.
- R10: If the holding register is empty at a frame start, the previous pair is resent and `underrun` is high for exactly one cycle.
- R11: `pad_oe` equals the inverse of `tristate` one cycle later. Frame timing continues unchanged while the pads are released.
- R12: After reset, `bclk_o`, `lrck_o`, `sdata_o` and `underrun` are 0, while `pad_oe` and `smp_ready` are 1. The first bit-clock rise starts period 0 of a frame, and the active pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Half-period enable for the bit clock |
| fmt_sel | input | 1 | Framing select: 0 left-justified, 1 I²S |
| width_sel | input | 5 | Requested sample width |
| tristate | input | 1 | Release the bus pads |
| smp_valid | input | 1 | Sample pair valid |
| smp_left | input | 24 | Left sample, right-aligned |
| smp_right | input | 24 | Right sample, right-aligned |
| smp_ready | output | 1 | Holding register empty |
| underrun | output | 1 | One-cycle pulse: frame started with no new pair |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| sdata_o | output | 1 | Serial data |
| pad_oe | output | 1 | Output enable for all three bus pads |

## Verification
The frame clock and the data bit of a period change on the same clock edge as the rise of the bit clock. The bench therefore finds each rise on the falling system-clock edge and captures both lines there. The underrun pulse is registered on the frame-start edge, so it is read at the same falling edge as period 0 and read again one edge later to confirm it has cleared. `pad_oe` and the drop of `smp_ready` after an accept are each due one clock after their cause, so both are read at the following falling edge. Every frame is compared as whole 64-bit data and frame-clock words, which the bench builds from its own shift model.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int SMP_W    = 24;
    localparam int MIN_W    = 16;
    localparam int SLOT_LEN = 32;
    localparam int POS_W    = $clog2(SLOT_LEN);
    localparam int CNT_W    = POS_W + 1;
    localparam int WSEL_W   = 5;
    localparam int IDX_W    = $clog2(SMP_W);

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef logic [WSEL_W-1:0] wsel_t;

    typedef struct packed {
        fmt_e  fmt;
        wsel_t width;
    } cfg_t;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } pair_t;

    // Force a requested width into the supported range.
    function automatic wsel_t clamp_width(input wsel_t req);
        if (int'(req) < MIN_W) return wsel_t'(MIN_W);
        if (int'(req) > SMP_W) return wsel_t'(SMP_W);
        return req;
    endfunction

    // Frame-clock level: left slot high for LJ, low for I2S.
    function automatic logic frame_level(input fmt_e fmt, input logic right_slot);
        return (fmt == FMT_LJ) ^ right_slot;
    endfunction

    // Data bit for a given slot position; I2S lags by one period.
    function automatic logic slot_bit(input cfg_t cfg,
                                      input logic [SMP_W-1:0] smp,
                                      input logic [POS_W-1:0] pos);
        int p;
        int w;
        int lead;
        int idx;
        p    = int'(pos);
        w    = int'(cfg.width);
        lead = (cfg.fmt == FMT_I2S) ? 1 : 0;
        if (p < lead || (p - lead) >= w) return 1'b0;
        idx = w - 1 - (p - lead);
        return smp[idx[IDX_W-1:0]];
    endfunction
endpackage

// File: rtl/pst_stage.sv
module pst_stage
    import pst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pair_t in_pair,
    output logic  in_ready,
    input  logic  take,
    output logic  held,
    output pair_t held_pair
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_pair <= '0;
        end else if (in_valid && !held) begin
            held      <= 1'b1;
            held_pair <= in_pair;
        end else if (take) begin
            held      <= 1'b0;
        end
    end

    assign in_ready = !held;
endmodule

// File: rtl/pst_clkgen.sv
module pst_clkgen
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic             bclk,
    output logic             rise,
    output logic             frame_start,
    output logic [POS_W-1:0] next_pos,
    output logic             next_right
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    assign rise        = tick && !bclk;
    assign cnt_nxt     = cnt + CNT_W'(1);
    assign frame_start = rise && (cnt_nxt == '0);
    assign next_pos    = cnt_nxt[POS_W-1:0];
    assign next_right  = cnt_nxt[CNT_W-1];

    // Counter resets to the last period so the first rise opens a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            bclk <= 1'b0;
            cnt  <= '1;
        end else begin
            if (tick) bclk <= !bclk;
            if (rise) cnt  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/pst_serializer.sv
module pst_serializer
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             frame_start,
    input  cfg_t             cfg_in,
    input  logic             staged,
    input  pair_t            staged_pair,
    input  logic [POS_W-1:0] next_pos,
    input  logic             next_right,
    output logic             lrck,
    output logic             sdata,
    output logic             underrun
);
    cfg_t             act_cfg;
    cfg_t             use_cfg;
    pair_t            act_pair;
    pair_t            use_pair;
    logic [SMP_W-1:0] use_smp;

    // At a frame start the new settings and pair bypass the active registers.
    always_comb begin
        use_cfg  = frame_start ? cfg_in : act_cfg;
        use_pair = (frame_start && staged) ? staged_pair : act_pair;
        use_smp  = next_right ? use_pair.right : use_pair.left;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg  <= '{fmt: FMT_LJ, width: wsel_t'(MIN_W)};
            act_pair <= '0;
            lrck     <= 1'b0;
            sdata    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= frame_start && !staged;
            if (frame_start) begin
                act_cfg  <= use_cfg;
                act_pair <= use_pair;
            end
            if (rise) begin
                lrck  <= frame_level(use_cfg.fmt, next_right);
                sdata <= slot_bit(use_cfg, use_smp, next_pos);
            end
        end
    end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              fmt_sel,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic              tristate,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_left,
    input  logic [SMP_W-1:0]  smp_right,
    output logic              smp_ready,
    output logic              underrun,
    output logic              bclk_o,
    output logic              lrck_o,
    output logic              sdata_o,
    output logic              pad_oe
);
    logic             rise;
    logic             frame_start;
    logic [POS_W-1:0] next_pos;
    logic             next_right;
    logic             staged;
    pair_t            staged_pair;
    pair_t            in_pair;
    cfg_t             cfg_in;

    assign in_pair = '{left: smp_left, right: smp_right};
    assign cfg_in  = '{fmt: fmt_e'(fmt_sel), width: clamp_width(width_sel)};

    pst_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (smp_valid),
        .in_pair   (in_pair),
        .in_ready  (smp_ready),
        .take      (frame_start),
        .held      (staged),
        .held_pair (staged_pair)
    );

    pst_clkgen u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .tick        (bit_tick),
        .bclk        (bclk_o),
        .rise        (rise),
        .frame_start (frame_start),
        .next_pos    (next_pos),
        .next_right  (next_right)
    );

    pst_serializer u_ser (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .frame_start (frame_start),
        .cfg_in      (cfg_in),
        .staged      (staged),
        .staged_pair (staged_pair),
        .next_pos    (next_pos),
        .next_right  (next_right),
        .lrck        (lrck_o),
        .sdata       (sdata_o),
        .underrun    (underrun)
    );

    // Pad enable only; the counters above never stop.
    always_ff @(posedge clk) begin
        if (rst) pad_oe <= 1'b1;
        else     pad_oe <= !tristate;
    end
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic tristate,
    input logic smp_valid,
    input logic smp_ready,
    input logic underrun,
    input logic bclk_o,
    input logic lrck_o,
    input logic sdata_o,
    input logic pad_oe
);
    assert_bclk_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(bclk_o));

    assert_bclk_step_R3: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> (bclk_o != $past(bclk_o)));

    assert_lines_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$rose(bclk_o) |-> ($stable(lrck_o) && $stable(sdata_o)));

    assert_accept_fills_R9: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_ready) |=> !smp_ready);

    assert_underrun_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        tristate |=> !pad_oe);

    assert_drive_R11: assert property (@(posedge clk) disable iff (rst)
        !tristate |=> pad_oe);
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .tristate  (tristate),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .underrun  (underrun),
    .bclk_o    (bclk_o),
    .lrck_o    (lrck_o),
    .sdata_o   (sdata_o),
    .pad_oe    (pad_oe)
);

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick;
    logic        fmt_sel;
    logic [4:0]  width_sel;
    logic        tristate;
    logic        smp_valid;
    logic [23:0] smp_left;
    logic [23:0] smp_right;
    logic        smp_ready;
    logic        underrun;
    logic        bclk_o;
    logic        lrck_o;
    logic        sdata_o;
    logic        pad_oe;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic prev_b = 1'b0;

    always #2 clk = !clk;

    pcm_serial_tx u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .fmt_sel(fmt_sel),
        .width_sel(width_sel), .tristate(tristate), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .smp_ready(smp_ready),
        .underrun(underrun), .bclk_o(bclk_o), .lrck_o(lrck_o),
        .sdata_o(sdata_o), .pad_oe(pad_oe)
    );

    // {fmt, width request, left, right}
    localparam int NV = 8;
    localparam logic [53:0] VEC [NV] = '{
        {1'b0, 5'd16, 24'hFFA5C3, 24'h00B00F},
        {1'b1, 5'd24, 24'h800001, 24'hFFFFFF},
        {1'b1, 5'd16, 24'h12C35A, 24'h00ABCD},
        {1'b0, 5'd24, 24'hC0FFEE, 24'h5A5A5A},
        {1'b0, 5'd20, 24'hF8ACE1, 24'h012345},
        {1'b1, 5'd18, 24'h03FFFE, 24'h02AAAB},
        {1'b0, 5'd8,  24'h33BEEF, 24'h447001},
        {1'b1, 5'd31, 24'h9ABCDE, 24'h765432}
    };

    function automatic int eff_w(input logic [4:0] r);
        if (r < 5'd16) return 16;
        if (r > 5'd24) return 24;
        return int'(r);
    endfunction

    function automatic logic [31:0] slot_word(input bit i2s, input int w, input logic [23:0] s);
        logic [31:0] m;
        m = {8'h00, s} & ((32'h1 << w) - 32'h1);
        return i2s ? (m << (31 - w)) : (m << (32 - w));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic pb;
        do begin
            @(negedge clk);
            pb     = prev_b;
            prev_b = bclk_o;
        end while (!(prev_b && !pb));
    endtask

    task automatic run_frame(input string tag, input logic [53:0] v, input bit exp_ur,
                             input bit push, input logic [53:0] nv, input bit ts);
        logic [63:0] dcap;
        logic [63:0] lcap;
        logic [63:0] dexp;
        logic [63:0] lexp;
        bit i2s;
        int w;
        i2s  = v[53];
        w    = eff_w(v[52:48]);
        dexp = {slot_word(i2s, w, v[47:24]), slot_word(i2s, w, v[23:0])};
        lexp = i2s ? {32'h0, 32'hFFFFFFFF} : {32'hFFFFFFFF, 32'h0};
        for (int k = 0; k < 64; k++) begin
            wait_rise();
            dcap[63-k] = sdata_o;
            lcap[63-k] = lrck_o;
            if (k == 0) begin
                check({tag, " R10 underrun flag at frame start"}, 64'(underrun), 64'(exp_ur));
                check({tag, " R9 ready after frame start"}, 64'(smp_ready), 64'd1);
                tristate = ts;
                if (push) begin
                    fmt_sel   = nv[53];
                    width_sel = nv[52:48];
                    smp_left  = nv[47:24];
                    smp_right = nv[23:0];
                    smp_valid = 1'b1;
                end
                @(negedge clk);
                prev_b = bclk_o;
                check({tag, " R10 underrun lasts one cycle"}, 64'(underrun), 64'd0);
                check({tag, " R4 lines hold on bclk fall"}, {62'd0, lrck_o, sdata_o},
                      {62'd0, lcap[63], dcap[63]});
            end
            if (k == 1) begin
                smp_valid = 1'b0;
                if (push) check({tag, " R9 ready low while holding"}, 64'(smp_ready), 64'd0);
                check({tag, " R11 pad enable follows tristate"}, 64'(pad_oe), 64'(!ts));
            end
        end
        check({tag, i2s ? " R1 R2 R8 R7 data" : " R1 R2 R8 R6 data"}, dcap, dexp);
        check({tag, " R5 frame clock"}, lcap, lexp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; bit_tick = 1'b0; fmt_sel = 1'b0; width_sel = 5'd16;
        tristate = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R12 reset state, R3 no toggle without tick
        check("R12 R3 bclk after reset", 64'(bclk_o), 64'd0);
        check("R12 lrck/sdata after reset", {62'd0, lrck_o, sdata_o}, 64'd0);
        check("R12 pad_oe/ready/underrun", {61'd0, pad_oe, smp_ready, underrun}, 64'b110);

        // preload first pair before ticks start
        fmt_sel   = VEC[0][53];
        width_sel = VEC[0][52:48];
        smp_left  = VEC[0][47:24];
        smp_right = VEC[0][23:0];
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R9 accept clears ready", 64'(smp_ready), 64'd0);
        prev_b   = bclk_o;
        bit_tick = 1'b1;

        // vector walk: settings for the next frame change mid-frame (R8)
        for (int i = 0; i < NV; i++) begin
            run_frame($sformatf("vec%0d", i), VEC[i], 1'b0, i < NV - 1,
                      (i < NV - 1) ? VEC[i+1] : VEC[i], 1'b0);
        end

        // R10: no pair staged, last one repeats; release pads (R11)
        run_frame("underrun", VEC[NV-1], 1'b1, 1'b1, VEC[3], 1'b1);
        // R11: pads back, frame alignment intact
        run_frame("realign", VEC[3], 1'b0, 1'b0, VEC[3], 1'b0);

        finish_run();
    end
endmodule